// File: doc/BRIEF.md
# Programmable-Range Cascadable Binary Counter

This block is a synchronous binary up-counter of parameterised width (four bits by default). It supports a synchronous clear, a synchronous parallel load and a count enable. A carry output is high whenever the count sits at its all-ones value. Several stages can be chained into a wider counter by gating each higher stage's enable with the lower stage's carry.

The counter can also be limited to a programmable range. A two-bit mode input selects the wrap behaviour:

- 00: plain binary counting.
- 01: on leaving all-ones, jump to a start value.
- 10: on reaching an end value, return to zero.
- 11: on reaching an end value, jump to the start value.

A wrap only ever happens on an enabled edge. The start and end values come in on ports, so software-free logic around the block can retarget the range on the fly.

Top module: `offs_counter`

## Requirements
- R1: When `clr` is high at a rising edge, the count becomes zero, overriding load, enable and any wrap.
- R2: When `ld` is high and `clr` is low at a rising edge, the count takes `ld_val`, with `ld_val[W-1]` as the most significant bit, whatever `en` or the mode is.
- R3: With `clr`, `ld` and `en` all low, the count holds its value, including at a wrap point.
- R4: `carry` is 1 exactly when every bit of `count` is 1 (15 for four bits), and 0 otherwise.
- R5: In mode 00 with `en` high, each edge adds one modulo 2^W, so 15 is followed by 0.
- R6: In mode 01 with `en` high, an edge at count all-ones loads `start_val` instead of wrapping to zero.
- R7: In mode 10 with `en` high, an edge at a count equal to `end_val` sets the count to zero.
- R8: In mode 11 with `en` high, an edge at a count equal to `end_val` loads `start_val`.
- R9: In modes 01, 10 and 11, an enabled edge away from the wrap point adds one modulo 2^W; in mode 10 a count above `end_val` runs up to all-ones and then to zero.
- R10: Two stages, with the upper stage enabled by the lower stage's enable ANDed with the lower carry, count as one 2W-bit binary counter, and the upper stage advances only on edges where the lower carry is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear, highest priority |
| ld | input | 1 | Synchronous parallel load |
| en | input | 1 | Count enable |
| ld_val | input | W | Parallel load value, bit W-1 most significant |
| start_val | input | W | Value loaded on a start-offset wrap |
| end_val | input | W | Terminal value compared in end-offset modes |
| mode | input | 2 | Wrap mode: 00 plain, 01 start, 10 end, 11 both |
| count | output | W | Current count |
| carry | output | 1 | High when count is all ones |

## Verification
The embedded properties check on every edge the control priority: clear, then load, then hold, then single increment. They also check the carry decode and the three wrap actions against the port values sampled one cycle earlier. Only the bench's scenarios show two things. The first is whole sequences: a counting loop closing on the programmed range, including a count that starts above the end value. The second is the behaviour of two chained stages as one wider counter, where the bench tracks the combined value over more than a full 8-bit period.

// File: rtl/offs_ctr_pkg.sv
package offs_ctr_pkg;

   typedef enum logic [1:0] {
      WRAP_NONE  = 2'b00,
      WRAP_START = 2'b01,
      WRAP_END   = 2'b10,
      WRAP_BOTH  = 2'b11
   } wrap_mode_e;

endpackage

// File: rtl/ctr_incr.sv
module ctr_incr #(
   parameter int W = 4
) (
   input  logic [W-1:0] q,
   output logic [W-1:0] q_inc,
   output logic         all_ones
);
   logic [W:0] low_set;

   assign low_set[0] = 1'b1;

   // Each bit flips when every lower bit is set; the chain end is the carry.
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign q_inc[i]     = q[i] ^ low_set[i];
      assign low_set[i+1] = low_set[i] & q[i];
   end

   assign all_ones = low_set[W];

endmodule

// File: rtl/ctr_wrap_sel.sv
module ctr_wrap_sel
   import offs_ctr_pkg::*;
#(
   parameter int W = 4
) (
   input  wrap_mode_e   mode,
   input  logic [W-1:0] q,
   input  logic         at_top,
   input  logic [W-1:0] start_val,
   input  logic [W-1:0] end_val,
   output logic         hit,
   output logic [W-1:0] target
);
   logic at_end;

   assign at_end = (q == end_val);

   always_comb begin
      hit    = 1'b0;
      target = '0;
      unique case (mode)
         WRAP_NONE:  begin hit = 1'b0;   target = '0;        end
         WRAP_START: begin hit = at_top; target = start_val; end
         WRAP_END:   begin hit = at_end; target = '0;        end
         WRAP_BOTH:  begin hit = at_end; target = start_val; end
         default:    begin hit = 1'b0;   target = '0;        end
      endcase
   end

endmodule

// File: rtl/ctr_stage.sv
module ctr_stage #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         clr,
   input  logic         ld,
   input  logic         en,
   input  logic [W-1:0] ld_val,
   input  logic         wrap_hit,
   input  logic [W-1:0] wrap_val,
   input  logic [W-1:0] q_inc,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (clr)      q <= '0;
      else if (ld)  q <= ld_val;
      else if (en)  q <= wrap_hit ? wrap_val : q_inc;
   end

   // Checks are enabled once a first clear has given the register a known value.
   logic armed_q = 1'b0;
   always_ff @(posedge clk) if (clr) armed_q <= 1'b1;

   p_clear_r1: assert property (@(posedge clk) disable iff (!armed_q)
      clr |=> (q == '0));
   p_load_r2: assert property (@(posedge clk) disable iff (!armed_q)
      (!clr && ld) |=> (q == $past(ld_val)));
   p_hold_r3: assert property (@(posedge clk) disable iff (!armed_q)
      (!clr && !ld && !en) |=> $stable(q));
   p_step_r5: assert property (@(posedge clk) disable iff (!armed_q)
      (!clr && !ld && en && !wrap_hit) |=> (q == $past(q) + 1'b1));

endmodule

// File: rtl/offs_counter.sv
module offs_counter
   import offs_ctr_pkg::*;
#(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         clr,
   input  logic         ld,
   input  logic         en,
   input  logic [W-1:0] ld_val,
   input  logic [W-1:0] start_val,
   input  logic [W-1:0] end_val,
   input  logic [1:0]   mode,
   output logic [W-1:0] count,
   output logic         carry
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   if (W < 2) begin : g_bad_width
      $error("offs_counter: W must be at least 2");
   end

   logic [W-1:0] q_inc;
   logic         top_q;
   logic         wrap_hit;
   logic [W-1:0] wrap_val;
   wrap_mode_e   mode_e;

   assign mode_e = wrap_mode_e'(mode);

   ctr_incr #(.W(W)) u_incr (
      .q        (count),
      .q_inc    (q_inc),
      .all_ones (top_q)
   );

   ctr_wrap_sel #(.W(W)) u_wrap (
      .mode      (mode_e),
      .q         (count),
      .at_top    (top_q),
      .start_val (start_val),
      .end_val   (end_val),
      .hit       (wrap_hit),
      .target    (wrap_val)
   );

   ctr_stage #(.W(W)) u_stage (
      .clk      (clk),
      .clr      (clr),
      .ld       (ld),
      .en       (en),
      .ld_val   (ld_val),
      .wrap_hit (wrap_hit),
      .wrap_val (wrap_val),
      .q_inc    (q_inc),
      .q        (count)
   );

   assign carry = top_q;

   logic armed_q = 1'b0;
   always_ff @(posedge clk) if (clr) armed_q <= 1'b1;

   p_carry_r4: assert property (@(posedge clk) disable iff (!armed_q)
      carry == (count == TOP));
   p_start_wrap_r6: assert property (@(posedge clk) disable iff (!armed_q)
      (mode == 2'b01 && !clr && !ld && en && count == TOP)
      |=> (count == $past(start_val)));
   p_end_clear_r7: assert property (@(posedge clk) disable iff (!armed_q)
      (mode == 2'b10 && !clr && !ld && en && count == end_val)
      |=> (count == '0));
   p_both_wrap_r8: assert property (@(posedge clk) disable iff (!armed_q)
      (mode == 2'b11 && !clr && !ld && en && count == end_val)
      |=> (count == $past(start_val)));

endmodule

// File: tb/tb_offs_counter.sv
module tb_offs_counter;
   localparam int CLK_P = 10;
   localparam int W = 4;

   logic clk = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   logic         clr = 1'b0, ld = 1'b0, en = 1'b0;
   logic [W-1:0] ld_val = '0, start_val = '0, end_val = '0;
   logic [1:0]   mode = 2'b00;
   logic [W-1:0] count;
   logic         carry;

   offs_counter #(.W(W)) dut (
      .clk(clk), .clr(clr), .ld(ld), .en(en), .ld_val(ld_val),
      .start_val(start_val), .end_val(end_val), .mode(mode),
      .count(count), .carry(carry)
   );

   // Two chained stages for the cascade scenario.
   logic         c_clr = 1'b0, c_en = 1'b0;
   logic [W-1:0] lo_q, hi_q;
   logic         lo_cy, hi_cy;

   offs_counter #(.W(W)) u_lo (
      .clk(clk), .clr(c_clr), .ld(1'b0), .en(c_en), .ld_val('0),
      .start_val('0), .end_val('0), .mode(2'b00), .count(lo_q), .carry(lo_cy)
   );
   offs_counter #(.W(W)) u_hi (
      .clk(clk), .clr(c_clr), .ld(1'b0), .en(c_en & lo_cy), .ld_val('0),
      .start_val('0), .end_val('0), .mode(2'b00), .count(hi_q), .carry(hi_cy)
   );

   int n_cmp = 0;
   int n_bad = 0;
   logic done = 1'b0;

   logic [W-1:0] exp_q[$];
   string        tag_q[$];
   logic [W-1:0] mdl = '0;

   function automatic logic [W-1:0] model_next(logic [W-1:0] cur, logic c, logic l,
         logic e, logic [1:0] m, logic [W-1:0] lv, logic [W-1:0] s, logic [W-1:0] ed);
      logic [W-1:0] top = {W{1'b1}};
      if (c) return '0;
      if (l) return lv;
      if (!e) return cur;
      case (m)
         2'b01:   return (cur == top) ? s : cur + 1'b1;
         2'b10:   return (cur == ed) ? '0 : cur + 1'b1;
         2'b11:   return (cur == ed) ? s : cur + 1'b1;
         default: return cur + 1'b1;
      endcase
   endfunction

   // Driver: sets inputs at the falling edge and queues the value expected after the next rise.
   task automatic step(input logic c, input logic l, input logic e, input logic [1:0] m,
         input logic [W-1:0] lv, input logic [W-1:0] s, input logic [W-1:0] ed,
         input string tag);
      @(negedge clk);
      clr = c; ld = l; en = e; mode = m; ld_val = lv; start_val = s; end_val = ed;
      mdl = model_next(mdl, c, l, e, m, lv, s, ed);
      exp_q.push_back(mdl);
      tag_q.push_back(tag);
      @(posedge clk);
   endtask

   // Monitor: compares one time unit after each rising edge.
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         logic [W-1:0] e_v;
         string t;
         e_v = exp_q.pop_front();
         t   = tag_q.pop_front();
         n_cmp++;
         if (count !== e_v) begin
            n_bad++;
            $display("FAIL %s count actual=%0d expected=%0d", t, count, e_v);
         end
         n_cmp++;
         if (carry !== (e_v == {W{1'b1}})) begin
            n_bad++;
            $display("FAIL R4 carry (%s) actual=%0b expected=%0b", t, carry, (e_v == {W{1'b1}}));
         end
      end
   end

   task automatic check8(input string tag, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   initial begin
      // R1 reset state by clear
      step(1, 0, 0, 2'b00, 4'd0, 4'd0, 4'd0, "R1");
      // R5 plain counting through the top and back to zero, carry at 15 (R4)
      for (int i = 0; i < 17; i++) step(0, 0, 1, 2'b00, 4'd0, 4'd0, 4'd0, "R5");
      // R3 hold with enable low
      for (int i = 0; i < 3; i++) step(0, 0, 0, 2'b00, 4'd9, 4'd0, 4'd0, "R3");
      // R2 load with enable low, bit 3 most significant: 4'b1010 = 10
      step(0, 1, 0, 2'b00, 4'b1010, 4'd0, 4'd0, "R2");
      // R1 clear beats load
      step(1, 1, 1, 2'b00, 4'd7, 4'd0, 4'd0, "R1");
      // R6 start-offset: from 13, 14, 15, then 6
      step(0, 1, 0, 2'b01, 4'd13, 4'd6, 4'd0, "R2");
      for (int i = 0; i < 5; i++) step(0, 0, 1, 2'b01, 4'd0, 4'd6, 4'd0, "R6");
      // R3 no wrap at 15 without enable; R2 load beats wrap
      step(0, 1, 0, 2'b01, 4'd15, 4'd6, 4'd0, "R2");
      step(0, 0, 0, 2'b01, 4'd0, 4'd6, 4'd0, "R3");
      step(0, 1, 1, 2'b01, 4'd3, 4'd6, 4'd0, "R2");
      // R7 end-offset at 13
      step(0, 1, 0, 2'b10, 4'd10, 4'd0, 4'd13, "R2");
      for (int i = 0; i < 5; i++) step(0, 0, 1, 2'b10, 4'd0, 4'd0, 4'd13, "R7");
      // R9 above end value: 14, 15, 0
      step(0, 1, 0, 2'b10, 4'd14, 4'd0, 4'd13, "R2");
      for (int i = 0; i < 3; i++) step(0, 0, 1, 2'b10, 4'd0, 4'd0, 4'd13, "R9");
      // R8 both offsets: 4 up to 13, then 6
      step(0, 1, 0, 2'b11, 4'd4, 4'd6, 4'd13, "R2");
      for (int i = 0; i < 12; i++) step(0, 0, 1, 2'b11, 4'd0, 4'd6, 4'd13, "R8");
      // R9 in mode 11 at 15 (not the end value) wraps to 0 by increment
      step(0, 1, 0, 2'b11, 4'd15, 4'd6, 4'd13, "R2");
      step(0, 0, 1, 2'b11, 4'd0, 4'd6, 4'd13, "R9");
      @(negedge clk); en = 1'b0;
      @(posedge clk); #2;

      // R10 cascade of two stages
      @(negedge clk); c_clr = 1'b1;
      @(negedge clk); c_clr = 1'b0;
      check8("R10 cleared", {hi_q, lo_q}, 8'd0);
      for (int i = 1; i <= 260; i++) begin
         @(negedge clk); c_en = 1'b1;
         @(posedge clk); #1;
         check8("R10 combined", {hi_q, lo_q}, 8'(i));
         if (i == 255) check8("R10 top carries", {7'd0, lo_cy & hi_cy}, 8'd1);
      end
      @(negedge clk); c_en = 1'b0;
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule